// File: doc/BRIEF.md
# Count-Based Victim Selector for a Fully Associative Cache

This unit makes the replacement decision for a small fully associative cache of `N` slots. Each slot records the block number it holds, whether it is occupied, how often it has been referenced, and its place in the load order. One block reference can arrive per clock. The unit compares the reference with every occupied slot at the same time and reports a hit or a miss. On a miss it chooses the slot that receives the block and updates its records.

A per-reference mode input sets the eviction rule once every slot is occupied. In one mode the slot with the fewest references is evicted. In the other mode the slot with the most references is evicted. When two or more slots tie on the deciding count, the slot that was loaded longest ago is evicted. The unit holds no cache data and drives no memory. A surrounding controller uses the reported slot to move the data.

Top module: `freq_victim_sel`

## Requirements
- R1: After reset every slot is empty, `out_valid` is 0 and `miss_count` is 0, so the first reference to any block is a miss.
- R2: A reference presented with `ref_valid` high at a clock edge produces `out_valid` high after that edge, together with its `out_hit` and `out_slot`. A clock edge with `ref_valid` low produces `out_valid` low. References may arrive on back-to-back cycles.
- R3: A reference hits when any occupied slot holds the same block number. On a hit, `out_slot` is the index of that slot and no slot contents change apart from that slot's counter.
- R4: While any slot is empty, a miss loads the block into the empty slot with the lowest index and evicts nothing. Occupied slots therefore always form a contiguous range starting at slot 0.
- R5: A newly loaded block starts with a count of 1. Every hit adds 1 to the count of the slot that was hit. The count saturates at 2^CW-1 and never wraps.
- R6: With `evict_high`=0 and all slots occupied, a miss evicts the slot with the smallest count. Among slots with equal counts, the one loaded earliest is evicted.
- R7: With `evict_high`=1 and all slots occupied, a miss evicts the slot with the largest count. Among slots with equal counts, the one loaded earliest is evicted.
- R8: `miss_count` increases by 1 in the same cycle as `out_valid` reports a miss. It holds its value on hits and on idle cycles.
- R9: With the least-frequent rule, the block sequence 3 2 3 6 7 3 3 5 4 gives the same miss total as a software model for cache sizes of 2, 3 and 4 slots. The same holds with the most-frequent rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_block | input | BW | Block number of the reference |
| evict_high | input | 1 | Eviction rule: 0 evicts the lowest count, 1 evicts the highest count |
| out_valid | output | 1 | Result of the previous cycle's reference is valid |
| out_hit | output | 1 | 1 for a hit, 0 for a miss |
| out_slot | output | SW | Slot that was hit or that received the block |
| miss_count | output | MCW | Running number of misses since reset |

## Verification
The bench targets ties on the deciding count. A design that breaks ties by slot index instead of by load order evicts the wrong slot as soon as an older block sits in a higher slot. The bench drives every count to the ceiling under the most-frequent rule. A counter that wraps would then look small, and the design would evict a slot other than the oldest one. The bench also fills from empty with an eviction pending. A design that evicts before all slots are occupied, or that fills a slot other than the lowest empty one, reports the wrong slot. The standard reference string and a long random run on 2-, 3- and 4-slot instances compare every hit, slot and miss total with a software model.

// File: rtl/freq_victim_sel.sv
module freq_victim_sel #(
  parameter int N   = 4,
  parameter int BW  = 8,
  parameter int CW  = 4,
  parameter int MCW = 16,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_valid,
  input  logic [BW-1:0]  ref_block,
  input  logic           evict_high,
  output logic           out_valid,
  output logic           out_hit,
  output logic [SW-1:0]  out_slot,
  output logic [MCW-1:0] miss_count
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [BW-1:0] blk_q  [N];
  logic [CW-1:0] cnt_q  [N];
  logic [SW-1:0] rank_q [N];
  logic [N-1:0]  vld;
  logic [N-1:0]  match;

  logic          hit_c, full_c;
  logic [SW-1:0] hit_idx, free_idx, vic_idx, sel_idx, fill_rank;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (blk_q[g] == ref_block);
  end

  assign hit_c     = |match;
  assign full_c    = &vld;
  assign fill_rank = SW'($countones(vld));

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) hit_idx = SW'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!vld[i]) free_idx = SW'(i);
  end

  always_comb begin
    logic better;
    vic_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (cnt_q[i] == cnt_q[vic_idx])
        better = rank_q[i] < rank_q[vic_idx];
      else if (evict_high)
        better = cnt_q[i] > cnt_q[vic_idx];
      else
        better = cnt_q[i] < cnt_q[vic_idx];
      if (better) vic_idx = SW'(i);
    end
  end

  assign sel_idx = hit_c ? hit_idx : (full_c ? vic_idx : free_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_slot   <= '0;
      miss_count <= '0;
      for (int i = 0; i < N; i++) begin
        blk_q[i]  <= '0;
        cnt_q[i]  <= '0;
        rank_q[i] <= '0;
      end
    end else begin
      out_valid <= ref_valid;
      if (ref_valid) begin
        out_hit  <= hit_c;
        out_slot <= sel_idx;
        if (hit_c) begin
          if (cnt_q[hit_idx] != CNT_MAX)
            cnt_q[hit_idx] <= cnt_q[hit_idx] + 1'b1;
        end else begin
          miss_count <= miss_count + 1'b1;
          for (int i = 0; i < N; i++) begin
            if (SW'(i) == sel_idx) begin
              vld[i]    <= 1'b1;
              blk_q[i]  <= ref_block;
              cnt_q[i]  <= CW'(1);
              rank_q[i] <= full_c ? SW'(N - 1) : fill_rank;
            end else if (full_c && rank_q[i] > rank_q[vic_idx]) begin
              rank_q[i] <= rank_q[i] - 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/freq_victim_sel_chk.sv
module freq_victim_sel_chk #(
  parameter int N   = 4,
  parameter int SW  = 2,
  parameter int MCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ref_valid,
  input logic           out_valid,
  input logic           out_hit,
  input logic [SW-1:0]  out_slot,
  input logic [MCW-1:0] miss_count,
  input logic [N-1:0]   vld
);

  logic [N:0] vld_ext;
  assign vld_ext = {1'b0, vld};

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) ref_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !ref_valid |=> !out_valid); // R2
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (int'(out_slot) < N)); // R3
  AST_NO_SLOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (($past(vld) & ~vld) == '0)); // R4
  AST_FILL_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n) (((vld_ext + 1'b1) & vld_ext) == '0)); // R4
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_hit) |-> (miss_count == MCW'($past(miss_count) + 1'b1))); // R8
  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_hit) |-> $stable(miss_count)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(miss_count)); // R8

endmodule

bind freq_victim_sel freq_victim_sel_chk #(.N(N), .SW(SW), .MCW(MCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .out_valid(out_valid),
  .out_hit(out_hit), .out_slot(out_slot), .miss_count(miss_count), .vld(vld)
);

// File: tb/tb_freq_victim_sel.sv
module tb_freq_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 15;

  logic clk = 0, rst_n = 0, ref_valid = 0, evict_high = 0;
  logic [7:0] ref_block = '0;

  logic        ov [3];
  logic        oh [3];
  int          os [3];
  int          om [3];
  logic [1:0]  s4, s3;
  logic        s2;
  logic [15:0] m4, m2, m3;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_victim_sel #(.N(4)) dut (.clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_block(ref_block),
    .evict_high(evict_high), .out_valid(ov[0]), .out_hit(oh[0]), .out_slot(s4), .miss_count(m4));
  freq_victim_sel #(.N(2)) dut_n2 (.clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_block(ref_block),
    .evict_high(evict_high), .out_valid(ov[1]), .out_hit(oh[1]), .out_slot(s2), .miss_count(m2));
  freq_victim_sel #(.N(3)) dut_n3 (.clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_block(ref_block),
    .evict_high(evict_high), .out_valid(ov[2]), .out_hit(oh[2]), .out_slot(s3), .miss_count(m3));

  assign os[0] = int'(s4); assign os[1] = int'(s2); assign os[2] = int'(s3);
  assign om[0] = int'(m4); assign om[1] = int'(m2); assign om[2] = int'(m3);

  int ns [3] = '{4, 2, 3};
  int m_blk [3][4];
  bit m_vld [3][4];
  int m_cnt [3][4];
  int m_rank[3][4];
  int m_miss[3];
  int checks = 0, errors = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < 3; k++) begin
      m_miss[k] = 0;
      for (int i = 0; i < 4; i++) begin
        m_vld[k][i] = 0; m_cnt[k][i] = 0; m_rank[k][i] = 0; m_blk[k][i] = 0;
      end
    end
  endfunction

  function automatic void step(int k, bit hi, int b, output bit h, output int s);
    int n = ns[k];
    int nv = 0;
    int v = 0;
    h = 0; s = -1;
    for (int i = 0; i < n; i++)
      if (m_vld[k][i] && m_blk[k][i] == b) begin h = 1; s = i; end
    if (h) begin
      if (m_cnt[k][s] < CMAX) m_cnt[k][s]++;
      return;
    end
    m_miss[k]++;
    for (int i = 0; i < n; i++) if (m_vld[k][i]) nv++;
    if (nv < n) begin
      for (int i = n - 1; i >= 0; i--) if (!m_vld[k][i]) s = i;
      m_rank[k][s] = nv;
    end else begin
      for (int i = 1; i < n; i++) begin
        bit better;
        if (m_cnt[k][i] == m_cnt[k][v]) better = m_rank[k][i] < m_rank[k][v];
        else if (hi) better = m_cnt[k][i] > m_cnt[k][v];
        else better = m_cnt[k][i] < m_cnt[k][v];
        if (better) v = i;
      end
      for (int i = 0; i < n; i++) if (m_rank[k][i] > m_rank[k][v]) m_rank[k][i]--;
      s = v;
      m_rank[k][s] = n - 1;
    end
    m_vld[k][s] = 1; m_blk[k][s] = b; m_cnt[k][s] = 1;
  endfunction

  task automatic do_reset();
    ref_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic issue(int b, bit hi, string tag);
    bit eh [3];
    int es [3];
    ref_valid = 1; ref_block = 8'(b); evict_high = hi;
    for (int k = 0; k < 3; k++) step(k, hi, b, eh[k], es[k]);
    @(negedge clk);
    ref_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk(ov[k] == 1'b1, "R2 out_valid", int'(ov[k]), 1);
      chk(oh[k] == eh[k], {tag, " hit"}, int'(oh[k]), int'(eh[k]));
      chk(os[k] == es[k], {tag, " slot"}, os[k], es[k]);
      chk(om[k] == m_miss[k], "R8 miss_count", om[k], m_miss[k]);
    end
  endtask

  task automatic idle();
    ref_valid = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(ov[k] == 1'b0, "R2 idle out_valid", int'(ov[k]), 0);
      chk(om[k] == m_miss[k], "R8 idle miss_count", om[k], m_miss[k]);
    end
  endtask

  int refstr [9] = '{3, 2, 3, 6, 7, 3, 3, 5, 4};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    for (int k = 0; k < 3; k++) begin
      chk(ov[k] == 1'b0, "R1 out_valid after reset", int'(ov[k]), 0);
      chk(om[k] == 0, "R1 miss_count after reset", om[k], 0);
    end

    // R4 fill order, R1 first references miss
    for (int i = 0; i < 4; i++) begin
      issue(10 + i, 0, "R4");
      chk(os[0] == i, "R4 lowest empty slot", os[0], i);
      chk(oh[0] == 1'b0, "R1 first reference misses", int'(oh[0]), 0);
    end
    issue(11, 0, "R3");
    chk(oh[0] == 1'b1 && os[0] == 1, "R3 hit on slot 1", os[0], 1);
    idle();

    // R9 reference string, both rules, R6/R7 per step
    for (int md = 0; md < 2; md++) begin
      do_reset();
      for (int i = 0; i < 9; i++) issue(refstr[i], md[0], md ? "R7" : "R6");
      for (int k = 0; k < 3; k++)
        chk(om[k] == m_miss[k], "R9 reference string miss total", om[k], m_miss[k]);
      $display("rule %0d misses: n4=%0d n2=%0d n3=%0d", md, m_miss[0], m_miss[1], m_miss[2]);
    end

    // R6 tie: equal counts, oldest first although in a higher slot
    do_reset();
    for (int i = 0; i < 4; i++) issue(20 + i, 0, "R4");
    issue(30, 0, "R6");
    chk(os[0] == 0, "R6 tie evicts oldest", os[0], 0);
    issue(31, 0, "R6");
    chk(os[0] == 1, "R6 tie evicts next oldest", os[0], 1);

    // R5 saturation under the high-count rule
    do_reset();
    for (int i = 0; i < 4; i++) issue(1 + i, 1, "R4");
    repeat (20) issue(1, 1, "R5");
    for (int b = 2; b <= 4; b++) repeat (14) issue(b, 1, "R5");
    issue(9, 1, "R7");
    chk(os[0] == 0, "R5 saturated counts tie, oldest evicted", os[0], 0);

    // Random mix
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else issue(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R6/R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule